// File: doc/BRIEF.md
# Float compare flag generator

This block compares two single-precision floating-point operands, called D and M, straight from their packed bit patterns. It returns a four-bit condition code in N, Z, C, V order, along with an invalid-operation flag. The comparison needs no unpacking and no normalisation. NaNs are found from the exponent and fraction fields. Equality treats both zeros as the same value. Ordering uses an unsigned comparison of the raw patterns, and that result is inverted when both operands are negative.

Two per-operation controls shape each comparison. `strict_nan` picks signalling comparison, in which every NaN raises invalid. When it is clear, only signalling NaNs raise invalid. `zero_m` replaces M with +0, which gives the compare-with-zero forms in both the quiet and the signalling variant. The logic is combinational. The parameter `REG_OUT` places a register on the outputs, and the default has that register.

Top module: `fcmp_flags`

## Requirements
- R1: The result is one of four codes on `nzcv` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V): D below M gives 4'b1000, equal gives 4'b0110, D above M gives 4'b0010, and unordered gives 4'b0011.
- R2: An operand is a NaN when its exponent field (bits 30..23) is all ones and its fraction (bits 22..0) is non-zero. Any NaN operand makes the result unordered. An infinity, which has a zero fraction, is ordered.
- R3: With `strict_nan` low, `invalid` is raised only when at least one operand is a NaN whose fraction MSB (bit 22) is clear. A quiet NaN, which has bit 22 set, is unordered without invalid.
- R4: With `strict_nan` high, `invalid` is raised whenever either operand is a NaN.
- R5: Two operands are equal when their bit patterns are identical, or when both have zero magnitude (bits 30..0 zero). So +0 equals -0.
- R6: When the sign bits (bit 31) differ and the operands are not both zeros, the operand with the sign bit set is the smaller one.
- R7: When the sign bits match, the unsigned comparison of the 32-bit patterns sets the order for positive operands. The order is reversed when both operands are negative.
- R8: With `zero_m` high, M is replaced by +0 (all bits zero). The value on `cmp_m`, even a signalling NaN, then has no effect on `nzcv` or `invalid`.
- R9: When neither operand is a NaN, `invalid` stays low.
- R10: With `REG_OUT`=1 (the default), the outputs show the result for the inputs sampled at the previous rising clock edge. An active-low reset clears `nzcv` and `invalid` to zero at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_d | input | 32 | First operand D, packed single precision |
| cmp_m | input | 32 | Second operand M, packed single precision |
| strict_nan | input | 1 | 1 selects signalling comparison, 0 selects quiet comparison |
| zero_m | input | 1 | 1 compares D against +0 in place of M |
| nzcv | output | 4 | Condition code {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Random patterns rarely hit the cases that matter most. These are a NaN with a chosen fraction MSB, two negatives whose patterns differ in only a few low bits, and a signalling NaN on M while compare-with-zero hides it. The stimulus therefore combines directed vectors with a pseudo-random stream. In that stream, exponent fields are forced to all ones and sign bits are forced equal at fixed intervals, and M is sometimes copied from D with a few low bits flipped. The reference model compares the operands as signed integers. It never uses the pattern inversion trick, so a fault in the inversion path cannot hide in the bench as well.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int NZCV_W = 4;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  // Condition codes, bit order {N,Z,C,V}
  localparam logic [NZCV_W-1:0] CC_LT = 4'b1000;
  localparam logic [NZCV_W-1:0] CC_EQ = 4'b0110;
  localparam logic [NZCV_W-1:0] CC_GT = 4'b0010;
  localparam logic [NZCV_W-1:0] CC_UN = 4'b0011;

  function automatic logic [NZCV_W-1:0] rel_to_cc(input rel_e r);
    case (r)
      REL_LT:  return CC_LT;
      REL_EQ:  return CC_EQ;
      REL_GT:  return CC_GT;
      default: return CC_UN;
    endcase
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] x,
  output logic                  is_nan,
  output logic                  is_snan,
  output logic                  zero_mag
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic exp_full;
  logic frac_nz;

  assign exp_full = &x[W-2:FRAC_W];
  assign frac_nz  = |x[FRAC_W-1:0];
  assign is_nan   = exp_full & frac_nz;
  // quiet marker is the top fraction bit
  assign is_snan  = is_nan & ~x[FRAC_W-1];
  assign zero_mag = ~|x[W-2:0];

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         eq,
  output logic         gt
);
  logic sign_a;
  logic sign_b;
  logic both_zero;
  logic raw_below;
  logic lt_pick;

  assign sign_a    = a[W-1];
  assign sign_b    = b[W-1];
  assign both_zero = ~|(a[W-2:0] | b[W-2:0]);
  assign raw_below = a < b;

  always_comb begin
    if (sign_a != sign_b) lt_pick = sign_a;
    else                  lt_pick = sign_a ^ raw_below;
  end

  assign eq = (a == b) | both_zero;
  assign lt = ~eq & lt_pick;
  assign gt = ~eq & ~lt_pick;

endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
  import fcmp_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXP_W+FRAC_W:0]   cmp_d,
  input  logic [EXP_W+FRAC_W:0]   cmp_m,
  input  logic                    strict_nan,
  input  logic                    zero_m,
  output logic [NZCV_W-1:0]       nzcv,
  output logic                    invalid
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [1:0][W-1:0] opnd;
  logic [1:0]        nan_v;
  logic [1:0]        snan_v;
  logic [1:0]        zmag_v;

  assign opnd[0] = cmp_d;
  assign opnd[1] = zero_m ? '0 : cmp_m;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .x        (opnd[g]),
      .is_nan   (nan_v[g]),
      .is_snan  (snan_v[g]),
      .zero_mag (zmag_v[g])
    );
  end

  logic ord_lt, ord_eq, ord_gt;

  fcmp_order #(.W(W)) u_ord (
    .a  (opnd[0]),
    .b  (opnd[1]),
    .lt (ord_lt),
    .eq (ord_eq),
    .gt (ord_gt)
  );

  // named events for the checks
  logic nan_any;
  logic snan_any;
  rel_e rel_c;
  logic [NZCV_W-1:0] cc_c;
  logic inv_c;

  assign nan_any  = |nan_v;
  assign snan_any = |snan_v;

  always_comb begin
    if (nan_any)     rel_c = REL_UN;
    else if (ord_lt) rel_c = REL_LT;
    else if (ord_gt) rel_c = REL_GT;
    else             rel_c = REL_EQ;
  end

  assign cc_c  = rel_to_cc(rel_c);
  assign inv_c = strict_nan ? nan_any : snan_any;

  if (REG_OUT) begin : g_reg
    logic [NZCV_W-1:0] cc_q;
    logic              inv_q;
    logic              armed;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cc_q  <= '0;
        inv_q <= 1'b0;
        armed <= 1'b0;
      end else begin
        cc_q  <= cc_c;
        inv_q <= inv_c;
        armed <= 1'b1;
      end
    end

    assign nzcv    = cc_q;
    assign invalid = inv_q;

    // R10: registered outputs lag the combinational result by one edge
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (nzcv == $past(cc_c)) && (invalid == $past(inv_c)));
  end else begin : g_comb
    assign nzcv    = cc_c;
    assign invalid = inv_c;
  end

  // R1: the order unit reports exactly one relation
  a_r1_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ord_lt, ord_eq, ord_gt}));

  // R2: a NaN from either classifier forces the unordered code
  a_r2_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    nan_any |-> (cc_c == CC_UN));

  // R4: signalling comparison flags every NaN
  a_r4_strict_any_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (strict_nan && nan_any) |-> inv_c);

  // R3: quiet comparison does not flag quiet NaNs
  a_r3_quiet_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!strict_nan && nan_any && !snan_any) |-> !inv_c);

  // R5: two zero magnitudes compare equal in the order unit
  a_r5_zeros_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (&zmag_v) |-> ord_eq);

  // R9: no NaN means no invalid
  a_r9_no_nan_no_inv: assert property (@(posedge clk) disable iff (!rst_n)
    !nan_any |-> !inv_c);

  // R8: compare-with-zero presents a clean +0 to the classifier
  a_r8_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    zero_m |-> (zmag_v[1] && !nan_v[1]));

endmodule

// File: tb/test_fcmp_flags.sv
`timescale 1ns/1ps
module test_fcmp_flags;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cmp_d = '0;
  logic [31:0] cmp_m = '0;
  logic        strict_nan = 1'b0;
  logic        zero_m = 1'b0;
  logic [3:0]  nzcv;
  logic        invalid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fcmp_flags i_fcmp_flags (
    .clk(clk), .rst_n(rst_n), .cmp_d(cmp_d), .cmp_m(cmp_m),
    .strict_nan(strict_nan), .zero_m(zero_m),
    .nzcv(nzcv), .invalid(invalid)
  );

  // behavioural reference: signed-integer view of each operand
  function automatic void model(input logic [31:0] d, input logic [31:0] m,
                                input bit s, input bit z,
                                output logic [3:0] f, output bit inv);
    bit nd, nm, sd, sm;
    longint kd, km;
    if (z) m = 32'h0;
    nd = (d[30:23] == 8'hFF) && (d[22:0] != 0);
    nm = (m[30:23] == 8'hFF) && (m[22:0] != 0);
    sd = nd && !d[22];
    sm = nm && !m[22];
    if (nd || nm) begin
      f = 4'b0011;
      inv = s ? 1'b1 : (sd || sm);
    end else begin
      inv = 1'b0;
      kd = d[31] ? -longint'(d[30:0]) : longint'(d[30:0]);
      km = m[31] ? -longint'(m[30:0]) : longint'(m[30:0]);
      if (kd < km)      f = 4'b1000;
      else if (kd > km) f = 4'b0010;
      else              f = 4'b0110;
    end
  endfunction

  logic [3:0] exp_f = '0;
  bit         exp_i = 1'b0;
  string      cur_tag = "R10";
  string      exp_tag = "R10";
  bit         exp_ok = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_f = '0;
      exp_i = 1'b0;
    end else begin
      model(cmp_d, cmp_m, strict_nan, zero_m, exp_f, exp_i);
    end
    exp_tag = cur_tag;
    exp_ok  = rst_n;
  end

  always @(negedge clk) begin
    if (rst_n && exp_ok && !done) begin
      checks++;
      if (nzcv !== exp_f || invalid !== exp_i) begin
        failures++;
        $display("FAIL %s d=%h m=%h: nzcv=%b invalid=%b expected nzcv=%b invalid=%b",
                 exp_tag, cmp_d, cmp_m, nzcv, invalid, exp_f, exp_i);
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if (nzcv !== 4'b0000 || invalid !== 1'b0) begin
      failures++;
      $display("FAIL %s reset: nzcv=%b invalid=%b expected nzcv=0000 invalid=0",
               tag, nzcv, invalid);
    end
  endtask

  task automatic drive(input logic [31:0] d, input logic [31:0] m,
                       input bit s, input bit z, input string tag);
    @(negedge clk);
    #1;
    cmp_d = d; cmp_m = m; strict_nan = s; zero_m = z; cur_tag = tag;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    #1;
    check_reset("R10_initial");
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;

    // R1 / R7 positive ordering
    drive(32'h3F800000, 32'h40000000, 0, 0, "R1_R7_lt");
    drive(32'h40000000, 32'h3F800000, 0, 0, "R1_R7_gt");
    drive(32'h3F800000, 32'h3F800000, 0, 0, "R1_R5_eq");
    // R5 signed zeros
    drive(32'h80000000, 32'h00000000, 0, 0, "R5_negzero");
    drive(32'h00000000, 32'h80000000, 1, 0, "R5_posneg");
    // R7 negatives reversed
    drive(32'hBF800000, 32'hC0000000, 0, 0, "R7_neg_gt");
    drive(32'hC0000000, 32'hBF800000, 0, 0, "R7_neg_lt");
    drive(32'hBF800001, 32'hBF800000, 0, 0, "R7_neg_lsb");
    // R6 sign differs
    drive(32'hBF800000, 32'h00000001, 0, 0, "R6_neg_small");
    drive(32'h00000001, 32'h80000000, 0, 0, "R6_pos_vs_negzero");
    drive(32'h80000000, 32'h3F800000, 0, 0, "R6_negzero_lt");
    // R2 infinity ordered, NaN unordered
    drive(32'h7F800000, 32'h7F7FFFFF, 0, 0, "R2_inf_gt");
    drive(32'hFF800000, 32'h7F800000, 0, 0, "R2_ninf_lt");
    drive(32'h7FC00000, 32'h3F800000, 0, 0, "R2_R3_qnan");
    drive(32'h7FC00000, 32'h7FC00000, 0, 0, "R2_same_nan");
    // R3 signalling NaN on either side
    drive(32'h7F800001, 32'h3F800000, 0, 0, "R3_snan_d");
    drive(32'h3F800000, 32'hFFA00000, 0, 0, "R3_snan_m");
    // R4 strict mode
    drive(32'h7FC00000, 32'h3F800000, 1, 0, "R4_strict_qnan");
    drive(32'h3F800000, 32'hFFFFFFFF, 1, 0, "R4_strict_qnan_m");
    drive(32'h3F800000, 32'h40000000, 1, 0, "R4_R9_strict_num");
    // R8 compare with zero, M ignored
    drive(32'hBF800000, 32'h7F800001, 0, 1, "R8_neg_vs_zero");
    drive(32'h80000000, 32'h7F800001, 1, 1, "R8_negzero");
    drive(32'h3F800000, 32'hFF800000, 0, 1, "R8_pos");
    drive(32'h7FC00000, 32'h00000000, 0, 1, "R8_R3_qnan_d");
    drive(32'h7F800001, 32'h3F800000, 1, 1, "R8_R4_snan_d");

    // R10 mid-run reset
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check_reset("R10_midrun");
    @(negedge clk);
    #1;
    rst_n = 1'b1;

    // R7 R9 pseudo-random stream with forced corner structure
    lf = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d, m;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      d = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      m = lf;
      if (i % 3 == 0) m[31] = d[31];
      if (i % 4 == 1) m = d ^ {29'h0, lf[2:0]};
      if (i % 7 == 2) d[30:23] = 8'hFF;
      if (i % 11 == 5) m[30:23] = 8'hFF;
      if (i % 13 == 6) begin d[30:0] = '0; m[30:0] = '0; end
      drive(d, m, lf[5], (i % 9 == 4), "R7_R9_random");
    end

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule